// File: doc/BRIEF.md
# Single-Register SPI Byte Port

This block is a byte-wide SPI peripheral that sits on a simple microcontroller register bus. One data register serves as both the transmit source and the shift register, so there is no holding stage for a second outgoing byte. Software writes a byte and the block shifts it out, MSB first, in SPI mode 0. The clock idles low, outgoing bits change on the falling SCK edge, and incoming bits are sampled on the rising edge. Each received byte is copied into a read buffer when the byte completes.

In master mode the block makes SCK from the system clock through one of four dividers, drives MOSI and samples MISO. In slave mode it passes the external SCK, MOSI and active-low select through two-flop synchronizers. It then follows that clock and drives MISO only while it is selected.

A write while a byte is still shifting is dropped and raises a collision flag, and the byte in flight carries on unchanged. Software can therefore keep rewriting the next byte until the collision flag stays clear. A write that lands on the exact cycle in which a byte finishes is accepted and starts the next byte at once. Two status flags report completion and collision. Each flag is cleared by a status read made while it is set, followed by any data-register access.

Top module: `spi_byte_port`

## Requirements
- R1: After synchronous reset, both status flags and the read buffer are zero, `sck_out` is low and `miso_drive` is low.
- R2: In master mode an accepted write shifts the byte out MSB first, with exactly eight rising SCK edges. MOSI is stable at each rising edge and SCK idles low. `cfg_div` sets SCK to the system clock divided by 4 (0), 16 (1), 64 (2) or 128 (3), so one byte lasts 8 x divisor system clocks.
- R3: In master mode `stat_done` is still low in the cycle before the last falling SCK edge. It reads high from the cycle after that edge, which is 8 x divisor clocks after the write is accepted.
- R4: A data write while a byte is in flight is discarded and sets `stat_coll`. The current byte is sent unchanged, and the discarded byte is never sent.
- R5: A write presented on the cycle in which a master byte completes is accepted without collision. The new byte follows with no idle cycles, and the just-received byte is not sent again.
- R6: `rdata` holds the most recently completed received byte.
- R7: A data-register access alone does not clear a set flag. A status read while the flag is set, followed by a data-register access (`bus_wr` or `bus_rd_data`), clears it.
- R8: In slave mode `sck_drive` and `sck_out` stay low; the block only follows `sck_in`.
- R9: In slave mode, with select low, the block receives eight bits from MOSI MSB first and sets `stat_done`. It transmits the loaded byte on MISO MSB first. Reception works with `sck_in` as fast as one quarter of the system clock.
- R10: Raising `ss_n_in` partway through a slave byte drops the partial byte without setting `stat_done`. The next selected byte is received whole.
- R11: In slave mode a write after the first rising SCK edge of a byte and before the byte completes is a collision. The loaded byte is still sent on MISO.
- R12: `miso_drive` is high only in slave mode while `ss_n_in` (after synchronization) is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_master | input | 1 | 1 = master, 0 = slave |
| cfg_div | input | 2 | Master SCK divider select (0:/4, 1:/16, 2:/64, 3:/128) |
| bus_wr | input | 1 | Data register write strobe |
| bus_wdata | input | DATA_W | Byte to transmit |
| bus_rd_data | input | 1 | Data register read strobe (used for flag clearing) |
| bus_rd_stat | input | 1 | Status register read strobe |
| rdata | output | DATA_W | Last completed received byte |
| stat_done | output | 1 | Transfer complete flag |
| stat_coll | output | 1 | Write collision flag |
| sck_out | output | 1 | Generated SCK (master) |
| sck_drive | output | 1 | Output enable for SCK |
| mosi_out | output | 1 | Serial data out (master) |
| miso_in | input | 1 | Serial data in (master) |
| sck_in | input | 1 | External SCK (slave) |
| ss_n_in | input | 1 | Active-low select (slave) |
| mosi_in | input | 1 | Serial data in (slave) |
| miso_out | output | 1 | Serial data out (slave) |
| miso_drive | output | 1 | Output enable for MISO |

## Verification
The sharpest corner is a write that lands exactly on the completing cycle of a master byte. A design that flags it as a collision, or that loads it too late, would send the received byte again as the second byte, and the bench compares that byte with what was written. A write part-way through a byte must be dropped; a design that queues or applies it would corrupt the bits on MOSI or add a ninth SCK pulse. The completion flag is sampled one cycle before and one cycle after the last falling SCK edge for every divider, which catches a flag raised a cycle early. On the slave side, the bench checks that an aborted partial byte leaves no completion behind and that a full-rate clock at one quarter of the system clock still yields the right byte.

// File: rtl/spi_byte_pkg.sv
package spi_byte_pkg;

    typedef enum logic [1:0] {
        DIV_4   = 2'd0,
        DIV_16  = 2'd1,
        DIV_64  = 2'd2,
        DIV_128 = 2'd3
    } spi_div_e;

    // one-cycle SCK edge events, whatever the clock source
    typedef struct packed {
        logic rise;
        logic fall;
    } sck_edge_t;

    // slave pins after synchronization; ss_n in the LSB
    typedef struct packed {
        logic sck;
        logic mosi;
        logic ss_n;
    } slave_pins_t;

    localparam int MAX_HALF = 64;

    // system clocks per SCK half period
    function automatic int half_period(spi_div_e d);
        case (d)
            DIV_4:   return 2;
            DIV_16:  return 8;
            DIV_64:  return 32;
            default: return 64;
        endcase
    endfunction

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
    parameter int          W       = 3,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_sck_src.sv
module spi_sck_src
    import spi_byte_pkg::*;
#(
    parameter int MAXH = MAX_HALF
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      master,
    input  logic      run,
    input  logic      restart,
    input  spi_div_e  div_sel,
    input  logic      sck_s,
    output logic      sck_q,
    output sck_edge_t ev
);
    localparam int CW = $clog2(MAXH);

    logic [CW-1:0] cnt;
    logic [CW-1:0] cnt_end;
    logic          prev;
    logic          tick;

    assign cnt_end = CW'(half_period(div_sel) - 1);
    assign tick    = master && run && (cnt == cnt_end);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            sck_q <= 1'b0;
            prev  <= 1'b0;
        end else begin
            prev <= sck_s;
            if (!master || !run || restart) begin
                cnt   <= '0;
                sck_q <= 1'b0;
            end else if (tick) begin
                cnt   <= '0;
                sck_q <= ~sck_q;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    always_comb begin
        if (master) begin
            ev.rise = tick && !sck_q;
            ev.fall = tick && sck_q;
        end else begin
            ev.rise = sck_s && !prev;
            ev.fall = !sck_s && prev;
        end
    end
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core
    import spi_byte_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         master,
    input  logic         sel,
    input  sck_edge_t    ev,
    input  logic         mosi_s,
    input  logic         miso_in,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic         busy,
    output logic         accept,
    output logic         collide,
    output logic         finish,
    output logic [W-1:0] rx_word,
    output logic         msb
);
    localparam int             BW   = $clog2(W);
    localparam logic [BW-1:0]  LAST = BW'(W - 1);

    logic [W-1:0]  shreg;
    logic [BW-1:0] bit_cnt;
    logic          mid;
    logic          samp;
    logic          active;
    logic [W-1:0]  shift_samp;
    logic [W-1:0]  shift_live;

    assign shift_samp = {shreg[W-2:0], samp};
    assign shift_live = {shreg[W-2:0], mosi_s};

    assign busy    = master ? active : (sel && ((bit_cnt != '0) || mid));
    assign finish  = master ? (active && ev.fall && (bit_cnt == LAST))
                            : (sel && ev.rise && (bit_cnt == LAST));
    // the completing cycle is open for the next byte
    assign accept  = wr_en && (!busy || finish);
    assign collide = wr_en && busy && !finish;
    assign rx_word = master ? shift_samp : shift_live;
    assign msb     = shreg[W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg   <= '0;
            bit_cnt <= '0;
            mid     <= 1'b0;
            samp    <= 1'b0;
            active  <= 1'b0;
        end else begin
            if (master) begin
                mid <= 1'b0;
                if (active && ev.rise) samp <= miso_in;
                if (active && ev.fall) begin
                    shreg   <= shift_samp;
                    bit_cnt <= bit_cnt + 1'b1;
                    if (bit_cnt == LAST) begin
                        active  <= 1'b0;
                        bit_cnt <= '0;
                    end
                end
            end else begin
                active <= 1'b0;
                if (!sel) begin
                    bit_cnt <= '0;
                    mid     <= 1'b0;
                end else if (ev.rise) begin
                    if (bit_cnt == LAST) begin
                        shreg   <= shift_live;
                        bit_cnt <= '0;
                        mid     <= 1'b0;
                    end else begin
                        samp <= mosi_s;
                        mid  <= 1'b1;
                    end
                end else if (ev.fall && mid) begin
                    shreg   <= shift_samp;
                    bit_cnt <= bit_cnt + 1'b1;
                    mid     <= 1'b0;
                end
            end
            // a new byte overrides the shift of the completing one
            if (accept) begin
                shreg <= wr_data;
                if (master) begin
                    active  <= 1'b1;
                    bit_cnt <= '0;
                end
            end
        end
    end
endmodule

// File: rtl/spi_flags.sv
module spi_flags #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set,
    input  logic         stat_rd,
    input  logic         data_acc,
    output logic [N-1:0] flag
);
    logic [N-1:0] arm;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= '0;
            arm  <= '0;
        end else begin
            for (int i = 0; i < N; i++) begin
                if (set[i])                     flag[i] <= 1'b1;
                else if (data_acc && arm[i])    flag[i] <= 1'b0;
                if (stat_rd)                    arm[i]  <= flag[i];
                else if (data_acc)              arm[i]  <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/spi_byte_port.sv
module spi_byte_port
    import spi_byte_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_master,
    input  logic [1:0]        cfg_div,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd_data,
    input  logic              bus_rd_stat,
    output logic [DATA_W-1:0] rdata,
    output logic              stat_done,
    output logic              stat_coll,
    output logic              sck_out,
    output logic              sck_drive,
    output logic              mosi_out,
    input  logic              miso_in,
    input  logic              sck_in,
    input  logic              ss_n_in,
    input  logic              mosi_in,
    output logic              miso_out,
    output logic              miso_drive
);
    localparam int NFLAG = 2;
    localparam int F_DONE = 0;
    localparam int F_COLL = 1;

    slave_pins_t       pin_raw;
    slave_pins_t       pin_s;
    logic              slave_sel;
    sck_edge_t         sck_ev;
    logic              sck_q;
    logic              core_busy;
    logic              core_accept;
    logic              core_collide;
    logic              core_finish;
    logic [DATA_W-1:0] core_rx;
    logic              core_msb;
    logic [NFLAG-1:0]  flag_set;
    logic [NFLAG-1:0]  flag_q;

    assign pin_raw = '{sck: sck_in, mosi: mosi_in, ss_n: ss_n_in};

    // ss_n resets to deselected
    spi_sync #(
        .W       ($bits(slave_pins_t)),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b001)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_raw),
        .q   (pin_s)
    );

    assign slave_sel = !pin_s.ss_n;

    spi_sck_src #(
        .MAXH (MAX_HALF)
    ) u_sck (
        .clk     (clk),
        .rst     (rst),
        .master  (cfg_master),
        .run     (core_busy),
        .restart (core_accept),
        .div_sel (spi_div_e'(cfg_div)),
        .sck_s   (pin_s.sck),
        .sck_q   (sck_q),
        .ev      (sck_ev)
    );

    spi_shift_core #(
        .W (DATA_W)
    ) u_core (
        .clk     (clk),
        .rst     (rst),
        .master  (cfg_master),
        .sel     (slave_sel),
        .ev      (sck_ev),
        .mosi_s  (pin_s.mosi),
        .miso_in (miso_in),
        .wr_en   (bus_wr),
        .wr_data (bus_wdata),
        .busy    (core_busy),
        .accept  (core_accept),
        .collide (core_collide),
        .finish  (core_finish),
        .rx_word (core_rx),
        .msb     (core_msb)
    );

    assign flag_set[F_DONE] = core_finish;
    assign flag_set[F_COLL] = core_collide;

    spi_flags #(
        .N (NFLAG)
    ) u_flags (
        .clk      (clk),
        .rst      (rst),
        .set      (flag_set),
        .stat_rd  (bus_rd_stat),
        .data_acc (bus_wr || bus_rd_data),
        .flag     (flag_q)
    );

    always_ff @(posedge clk) begin
        if (rst)              rdata <= '0;
        else if (core_finish) rdata <= core_rx;
    end

    assign stat_done  = flag_q[F_DONE];
    assign stat_coll  = flag_q[F_COLL];
    assign sck_out    = cfg_master && sck_q;
    assign sck_drive  = cfg_master;
    assign mosi_out   = cfg_master && core_msb;
    assign miso_drive = !cfg_master && slave_sel;
    assign miso_out   = miso_drive && core_msb;
endmodule

// File: rtl/spi_byte_port_chk.sv
module spi_byte_port_chk
    import spi_byte_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_master,
    input logic [1:0]        cfg_div,
    input logic              bus_wr,
    input logic              stat_done,
    input logic              stat_coll,
    input logic [DATA_W-1:0] rdata,
    input logic              core_busy,
    input logic              core_finish,
    input logic              core_accept,
    input logic              slave_sel
);
    logic [15:0] cyc;

    always_ff @(posedge clk) begin
        if (rst)              cyc <= '0;
        else if (core_accept) cyc <= '0;
        else if (core_busy)   cyc <= cyc + 1'b1;
    end

    p_byte_len_r2: assert property (@(posedge clk) disable iff (rst)
        (cfg_master && core_finish) |->
            (cyc == 16'(16 * half_period(spi_div_e'(cfg_div)) - 1)));

    p_done_after_finish_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(stat_done) |-> $past(core_finish));

    p_coll_from_write_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(stat_coll) |-> $past(bus_wr && core_busy));

    p_edge_write_starts_r5: assert property (@(posedge clk) disable iff (rst)
        (cfg_master && core_finish && bus_wr) |=> core_busy);

    p_rdata_moves_with_done_r6: assert property (@(posedge clk) disable iff (rst)
        !$stable(rdata) |-> stat_done);

    p_deselect_no_done_r10: assert property (@(posedge clk) disable iff (rst)
        (!cfg_master && !slave_sel) |=> !$rose(stat_done));
endmodule

bind spi_byte_port spi_byte_port_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cfg_master  (cfg_master),
    .cfg_div     (cfg_div),
    .bus_wr      (bus_wr),
    .stat_done   (stat_done),
    .stat_coll   (stat_coll),
    .rdata       (rdata),
    .core_busy   (core_busy),
    .core_finish (core_finish),
    .core_accept (core_accept),
    .slave_sel   (slave_sel)
);

// File: tb/spi_byte_port_bench.sv
module spi_byte_port_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_master = 1'b1;
    logic [1:0] cfg_div = 2'd0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic       bus_rd_data = 1'b0;
    logic       bus_rd_stat = 1'b0;
    logic [7:0] rdata;
    logic       stat_done, stat_coll;
    logic       sck_out, sck_drive, mosi_out, miso_in;
    logic       sck_in = 1'b0;
    logic       ss_n_in = 1'b1;
    logic       mosi_in = 1'b0;
    logic       miso_out, miso_drive;

    int checks = 0;
    int errors = 0;

    // external slave model for master mode
    logic [15:0] ms_tx16 = 16'h0;
    logic [15:0] ms_rx16 = 16'h0;
    int          ms_bits = 0;
    logic [7:0]  so_cap  = 8'h0;

    always #4 clk = ~clk;

    spi_byte_port u_spi_byte_port (
        .clk (clk), .rst (rst), .cfg_master (cfg_master), .cfg_div (cfg_div),
        .bus_wr (bus_wr), .bus_wdata (bus_wdata), .bus_rd_data (bus_rd_data),
        .bus_rd_stat (bus_rd_stat), .rdata (rdata), .stat_done (stat_done),
        .stat_coll (stat_coll), .sck_out (sck_out), .sck_drive (sck_drive),
        .mosi_out (mosi_out), .miso_in (miso_in), .sck_in (sck_in),
        .ss_n_in (ss_n_in), .mosi_in (mosi_in), .miso_out (miso_out),
        .miso_drive (miso_drive)
    );

    assign miso_in = ms_tx16[15];

    always @(posedge sck_out) begin
        ms_rx16 = {ms_rx16[14:0], mosi_out};
        ms_bits = ms_bits + 1;
    end

    always @(negedge sck_out) ms_tx16 = {ms_tx16[14:0], 1'b0};

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int divisor(input logic [1:0] d);
        case (d)
            2'd0:    return 4;
            2'd1:    return 16;
            2'd2:    return 64;
            default: return 128;
        endcase
    endfunction

    task automatic do_write(input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1;
        bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic pulse_stat();
        @(negedge clk); bus_rd_stat = 1'b1;
        @(negedge clk); bus_rd_stat = 1'b0;
    endtask

    task automatic pulse_data_rd();
        @(negedge clk); bus_rd_data = 1'b1;
        @(negedge clk); bus_rd_data = 1'b0;
    endtask

    task automatic clear_flags();
        pulse_stat();
        pulse_data_rd();
    endtask

    task automatic slave_shift(input logic [7:0] mo, input int half, input int hi, input int lo);
        for (int i = hi; i >= lo; i--) begin
            mosi_in = mo[i];
            repeat (half) @(negedge clk);
            so_cap[i] = miso_out;
            sck_in = 1'b1;
            repeat (half) @(negedge clk);
            sck_in = 1'b0;
        end
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 done", stat_done, 0);
        check("R1 coll", stat_coll, 0);
        check("R1 rdata", rdata, 0);
        check("R1 sck", sck_out, 0);
        check("R1 miso_drive", miso_drive, 0);
    endtask

    task automatic t_master_byte(input logic [1:0] dsel, input logic [7:0] tx, input logic [7:0] mi);
        int n;
        n = divisor(dsel);
        @(negedge clk);
        cfg_master = 1'b1;
        cfg_div = dsel;
        clear_flags();
        ms_tx16 = {mi, 8'h00};
        ms_rx16 = 16'h0;
        ms_bits = 0;
        do_write(tx);
        repeat (8 * n - 1) @(posedge clk);
        @(negedge clk);
        check("R3 done not early", stat_done, 0);
        @(posedge clk);
        @(negedge clk);
        check("R3 done on time", stat_done, 1);
        check("R2 mosi byte", ms_rx16[7:0], tx);
        check("R2 sck edges", ms_bits, 8);
        check("R2 sck idle", sck_out, 0);
        check("R6 rdata", rdata, mi);
    endtask

    task automatic t_master_coll();
        @(negedge clk);
        cfg_master = 1'b1;
        cfg_div = 2'd0;
        clear_flags();
        ms_tx16 = {8'h3C, 8'h00};
        ms_rx16 = 16'h0;
        ms_bits = 0;
        do_write(8'hA5);
        repeat (6) @(negedge clk);
        do_write(8'h0F);
        check("R4 coll set", stat_coll, 1);
        check("R4 no done yet", stat_done, 0);
        repeat (40) @(negedge clk);
        check("R4 byte intact", ms_rx16[7:0], 8'hA5);
        check("R4 no extra byte", ms_bits, 8);
        check("R4 rdata", rdata, 8'h3C);
        // flag clearing
        pulse_data_rd();
        check("R7 data access alone", stat_coll, 1);
        pulse_stat();
        check("R7 stat read alone", stat_coll, 1);
        pulse_data_rd();
        check("R7 coll cleared", stat_coll, 0);
        check("R7 done cleared", stat_done, 0);
    endtask

    task automatic t_back_to_back();
        @(negedge clk);
        cfg_master = 1'b1;
        cfg_div = 2'd0;
        clear_flags();
        ms_tx16 = {8'h81, 8'h7E};
        ms_rx16 = 16'h0;
        ms_bits = 0;
        do_write(8'hC3);
        repeat (31) @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b1;
        bus_wdata = 8'h5A;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
        check("R5 no collision", stat_coll, 0);
        check("R5 first done", stat_done, 1);
        check("R6 first rdata", rdata, 8'h81);
        repeat (32) @(posedge clk);
        @(negedge clk);
        check("R5 both bytes", ms_rx16, 16'hC35A);
        check("R5 sixteen edges", ms_bits, 16);
        check("R6 second rdata", rdata, 8'h7E);
    endtask

    task automatic t_slave_byte();
        @(negedge clk);
        cfg_master = 1'b0;
        ss_n_in = 1'b1;
        clear_flags();
        do_write(8'h96);
        check("R12 no drive deselected", miso_drive, 0);
        ss_n_in = 1'b0;
        repeat (4) @(negedge clk);
        check("R12 drive selected", miso_drive, 1);
        check("R8 sck_drive low", sck_drive, 0);
        slave_shift(8'h4D, 6, 7, 0);
        check("R8 sck_out low", sck_out, 0);
        repeat (6) @(negedge clk);
        check("R9 slave done", stat_done, 1);
        check("R9 slave rx", rdata, 8'h4D);
        check("R9 slave tx", so_cap, 8'h96);
        ss_n_in = 1'b1;
        repeat (4) @(negedge clk);
        check("R12 drive released", miso_drive, 0);
    endtask

    task automatic t_slave_fast();
        clear_flags();
        ss_n_in = 1'b0;
        repeat (4) @(negedge clk);
        slave_shift(8'hB2, 2, 7, 0);
        repeat (6) @(negedge clk);
        check("R9 quarter rate done", stat_done, 1);
        check("R9 quarter rate rx", rdata, 8'hB2);
        ss_n_in = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_slave_abort();
        clear_flags();
        ss_n_in = 1'b0;
        repeat (4) @(negedge clk);
        slave_shift(8'hFF, 6, 7, 5);
        ss_n_in = 1'b1;
        repeat (8) @(negedge clk);
        check("R10 no done on abort", stat_done, 0);
        ss_n_in = 1'b0;
        repeat (4) @(negedge clk);
        slave_shift(8'h29, 6, 7, 0);
        repeat (6) @(negedge clk);
        check("R10 next byte done", stat_done, 1);
        check("R10 next byte rx", rdata, 8'h29);
        ss_n_in = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_slave_coll();
        clear_flags();
        do_write(8'hE1);
        ss_n_in = 1'b0;
        repeat (4) @(negedge clk);
        slave_shift(8'h17, 6, 7, 6);
        do_write(8'h00);
        check("R11 slave coll", stat_coll, 1);
        check("R11 no done mid byte", stat_done, 0);
        slave_shift(8'h17, 6, 5, 0);
        repeat (6) @(negedge clk);
        check("R11 tx intact", so_cap, 8'hE1);
        check("R11 rx", rdata, 8'h17);
        ss_n_in = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        t_reset();
        t_master_byte(2'd0, 8'hA6, 8'h5B);
        t_master_byte(2'd1, 8'h31, 8'hC8);
        t_master_byte(2'd2, 8'hF0, 8'h0D);
        t_master_byte(2'd3, 8'h1E, 8'hE7);
        t_master_coll();
        t_back_to_back();
        t_slave_byte();
        t_slave_fast();
        t_slave_abort();
        t_slave_coll();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule